// File: doc/BRIEF.md
# VME Bus Requester with Release Control

This block is the arbitration front end of a single VME master port that several internal channels share. When any channel wants the bus, it raises one of the four bus request lines. A two-bit configuration input picks which line, and every channel uses that same line. The block then waits for the daisy-chained grant, takes bus busy and drops its request. Only after that does it hand the master port to one channel. Grants that arrive while the block is not waiting for one are forwarded down the chain.

Two policy inputs shape its manners on the bus. The fairness input decides whether the block holds back while another master is already requesting on the same level. The release input decides when bus busy is given up. In release-when-done it is dropped as soon as the owning channel's access ends. In release-on-request it is kept until another master asks for the bus. While it is kept, ownership passes from one internal channel to the next with no new bus arbitration. A channel signals the end of a whole access, however many bursts it was split into, with one pulse on its done or bus-error input.

Top module: `vme_requester`

## Requirements
- R1: After reset `br_out`, `bbsy` and `ch_gnt` are all zero. While requesting, `br_out` has exactly bit `cfg_lvl` set (bit 0 for level 0 up to bit 3 for level 3). Otherwise `br_out` is zero.
- R2: The request line used is the one selected by `cfg_lvl`, whichever channel raised the need.
- R3: With `cfg_fair`=1, no request is raised in a cycle that follows one where `br_in[cfg_lvl]` was high while idle. The request appears on the clock after a cycle in which that line was low and a channel was requesting.
- R4: With `cfg_fair`=0, `br_out` rises on the clock after any `ch_req` bit is seen while idle, whatever `br_in` shows.
- R5: If `bg_in` is high while requesting, then on the next clock `bbsy`=1 and `br_out`=0. One clock later exactly one channel's `ch_gnt` bit is set.
- R6: With `cfg_ror`=0, `bbsy` falls on the clock after the owning channel pulses `ch_done`.
- R7: A `ch_berr` pulse from the owner ends its access exactly like `ch_done`.
- R8: With `cfg_ror`=1, `bbsy` stays high while the owner is busy, even if `br_in` has bits set. It falls on the clock after the owner finishes while any `br_in` bit is high.
- R9: With `cfg_ror`=1, if the owner finishes while `br_in` is all zero, the next requesting channel owns the port on the next clock with `bbsy` still high and `br_out` zero. If no channel is requesting, `bbsy` is held with no owner until a channel requests (it is granted on the next clock) or a `br_in` bit rises (the bus is released on the next clock).
- R10: `bg_out` follows `bg_in` in every cycle except those in which the block is requesting, when it is 0.
- R11: Competing channels are served in round-robin order starting after the last owner (channel 0 first after reset). At most one `ch_gnt` bit is ever set.
- R12: On the clock where `bbsy` falls, `br_out` is zero, so at least one clock without `bbsy` passes before a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lvl | input | 2 | Request level to use (0..3) |
| cfg_fair | input | 1 | 1: fair request policy, 0: demand |
| cfg_ror | input | 1 | 1: release on request, 0: release when done |
| ch_req | input | N_CH | Per-channel need for the master port |
| ch_done | input | N_CH | Per-channel pulse: whole access finished |
| ch_berr | input | N_CH | Per-channel pulse: access ended by bus error |
| br_in | input | 4 | Sampled bus request lines, bit n is level n |
| bg_in | input | 1 | Daisy-chain grant in for the selected level |
| br_out | output | 4 | Bus request drive, bit n is level n |
| bbsy | output | 1 | Bus busy drive |
| bg_out | output | 1 | Daisy-chain grant out |
| ch_gnt | output | N_CH | One-hot ownership of the master port |

## Verification
The risky overlaps are the owner finishing in the same cycle that another master's request appears on `br_in`, and in the same cycle that another channel raises `ch_req`. Under release-on-request, these decide between giving up the bus and passing it to another channel. Directed steps place the done pulse, the foreign request and a new channel request on one edge. The bench also steers a grant onto the clock where the block is still requesting, which must swallow the grant rather than forward it. A behavioural model, stepped every clock through a long random phase, judges every output on each cycle, so these coincidences are also met in orders the directed steps do not list.

// File: rtl/vme_req_pkg.sv
package vme_req_pkg;

    localparam int unsigned NUM_LVL = 4;
    localparam int unsigned LVL_W   = $clog2(NUM_LVL);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // bus not held, not asking
        ST_REQ   = 3'd1,   // request line driven, awaiting grant
        ST_SEIZE = 3'd2,   // busy taken, request dropped, no owner yet
        ST_OWN   = 3'd3,   // one channel owns the master port
        ST_PARK  = 3'd4    // busy kept, no owner (release-on-request)
    } req_st_e;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             fair;
        logic             ror;
    } req_cfg_t;

    function automatic logic [NUM_LVL-1:0] lvl_hot(input logic [LVL_W-1:0] l);
        lvl_hot = NUM_LVL'(1) << l;
    endfunction

    function automatic logic holds_bus(input req_st_e s);
        holds_bus = (s == ST_SEIZE) || (s == ST_OWN) || (s == ST_PARK);
    endfunction

endpackage

// File: rtl/vme_rr_arb.sv
module vme_rr_arb #(
    parameter int unsigned N  = 4,
    localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] pick,
    output logic          vld
);
    logic [CW:0] scan;

    // Scan from last+N down to last+1 so the nearest successor wins.
    always_comb begin
        pick = '0;
        vld  = 1'b0;
        scan = '0;
        for (int k = N; k >= 1; k--) begin
            scan = {1'b0, last} + (CW+1)'(k);
            if (scan >= (CW+1)'(N)) scan = scan - (CW+1)'(N);
            if (req[scan[CW-1:0]]) begin
                pick = scan[CW-1:0];
                vld  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vme_bus_lines.sv
module vme_bus_lines
    import vme_req_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LVL_W-1:0]    lvl,
    input  logic                drive_req,
    input  logic                bg_in,
    output logic [NUM_LVL-1:0]  br_out,
    output logic                bg_out
);
    logic [NUM_LVL-1:0] sel;
    assign sel = lvl_hot(lvl);

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign br_out[g] = drive_req & sel[g];
    end

    // A grant is consumed only while this block is asking for one.
    assign bg_out = bg_in & ~drive_req;

    a_r10_grant_forward: assert property (@(posedge clk) disable iff (rst)
        (!(|br_out) && bg_in) |-> bg_out);

    a_r1_single_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(br_out));

endmodule

// File: rtl/vme_requester.sv
module vme_requester
    import vme_req_pkg::*;
#(
    parameter int unsigned N_CH = 4,
    localparam int unsigned CW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LVL_W-1:0]   cfg_lvl,
    input  logic               cfg_fair,
    input  logic               cfg_ror,
    input  logic [N_CH-1:0]    ch_req,
    input  logic [N_CH-1:0]    ch_done,
    input  logic [N_CH-1:0]    ch_berr,
    input  logic [NUM_LVL-1:0] br_in,
    input  logic               bg_in,
    output logic [NUM_LVL-1:0] br_out,
    output logic               bbsy,
    output logic               bg_out,
    output logic [N_CH-1:0]    ch_gnt
);
    req_cfg_t         cfg;
    req_st_e          st_q;
    logic [CW-1:0]    own_q, last_q;
    logic [N_CH-1:0]  own_mask, arb_req;
    logic [CW-1:0]    arb_pick;
    logic             arb_vld;
    logic             acc_end, foreign_req, lvl_busy;

    assign cfg         = '{lvl: cfg_lvl, fair: cfg_fair, ror: cfg_ror};
    assign own_mask    = N_CH'(1) << own_q;
    assign acc_end     = |(own_mask & (ch_done | ch_berr));
    assign foreign_req = |br_in;
    assign lvl_busy    = br_in[cfg.lvl];
    assign arb_req     = (st_q == ST_OWN) ? (ch_req & ~own_mask) : ch_req;

    vme_rr_arb #(.N(N_CH)) i_arb (
        .req  (arb_req),
        .last (last_q),
        .pick (arb_pick),
        .vld  (arb_vld)
    );

    vme_bus_lines i_lines (
        .clk       (clk),
        .rst       (rst),
        .lvl       (cfg.lvl),
        .drive_req (st_q == ST_REQ),
        .bg_in     (bg_in),
        .br_out    (br_out),
        .bg_out    (bg_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            own_q  <= '0;
            last_q <= CW'(N_CH - 1);
        end else begin
            unique case (st_q)
                ST_IDLE:
                    if (|ch_req && !(cfg.fair && lvl_busy)) st_q <= ST_REQ;
                ST_REQ:
                    if (bg_in) st_q <= ST_SEIZE;
                ST_SEIZE:
                    if (arb_vld) begin
                        st_q   <= ST_OWN;
                        own_q  <= arb_pick;
                        last_q <= arb_pick;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                ST_OWN:
                    if (acc_end) begin
                        if (!cfg.ror || foreign_req) begin
                            st_q <= ST_IDLE;
                        end else if (arb_vld) begin
                            own_q  <= arb_pick;
                            last_q <= arb_pick;
                        end else begin
                            st_q <= ST_PARK;
                        end
                    end
                ST_PARK:
                    if (foreign_req) begin
                        st_q <= ST_IDLE;
                    end else if (arb_vld) begin
                        st_q   <= ST_OWN;
                        own_q  <= arb_pick;
                        last_q <= arb_pick;
                    end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign bbsy   = holds_bus(st_q);
    assign ch_gnt = (st_q == ST_OWN) ? own_mask : '0;

    a_r11_one_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_gnt));

    a_r5_owner_has_bus: assert property (@(posedge clk) disable iff (rst)
        (|ch_gnt) |-> (bbsy && br_out == '0));

    a_r5_seize: assert property (@(posedge clk) disable iff (rst)
        ((|br_out) && bg_in) |=> (bbsy && br_out == '0 && ch_gnt == '0));

    a_r6_release_done: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ror && (|(ch_gnt & (ch_done | ch_berr)))) |=> !bbsy);

    a_r3_fair_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_fair && !bbsy && br_out == '0 && br_in[cfg_lvl]) |=> br_out == '0);

    a_r9_handoff_after_end: assert property (@(posedge clk) disable iff (rst)
        ((|ch_gnt) && (|$past(ch_gnt)) && ch_gnt != $past(ch_gnt))
            |-> $past(|(ch_gnt & (ch_done | ch_berr))));

    a_r12_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(bbsy) |-> br_out == '0);

endmodule

// File: tb/test_vme_requester.sv
`timescale 1ns/1ps
module test_vme_requester;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_lvl = 2'd3;
    logic          cfg_fair = 1'b0, cfg_ror = 1'b0;
    logic [NC-1:0] ch_req = '0, ch_done = '0, ch_berr = '0;
    logic [3:0]    br_in = '0;
    logic          bg_in = 1'b0;
    logic [3:0]    br_out;
    logic          bbsy, bg_out;
    logic [NC-1:0] ch_gnt;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vme_requester #(.N_CH(NC)) i_vme_requester (
        .clk(clk), .rst(rst), .cfg_lvl(cfg_lvl), .cfg_fair(cfg_fair),
        .cfg_ror(cfg_ror), .ch_req(ch_req), .ch_done(ch_done),
        .ch_berr(ch_berr), .br_in(br_in), .bg_in(bg_in),
        .br_out(br_out), .bbsy(bbsy), .bg_out(bg_out), .ch_gnt(ch_gnt)
    );

    // Behavioural reference: phase 0 idle, 1 asking, 2 just granted,
    // 3 channel owns port, 4 holding bus with nobody using it.
    int phase = 0, owner = 0, prev = NC - 1;

    function automatic int next_in_turn(logic [NC-1:0] want, int after);
        for (int d = 1; d <= NC; d++) begin
            if (want[(after + d) % NC]) return (after + d) % NC;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            phase = 0; owner = 0; prev = NC - 1;
        end else begin
            int who;
            case (phase)
                0: if (ch_req != 0 && !(cfg_fair && br_in[cfg_lvl])) phase = 1;
                1: if (bg_in) phase = 2;
                2: begin
                    who = next_in_turn(ch_req, prev);
                    if (who < 0) phase = 0;
                    else begin phase = 3; owner = who; prev = who; end
                end
                3: if (ch_done[owner] || ch_berr[owner]) begin
                    logic [NC-1:0] others;
                    others = ch_req;
                    others[owner] = 1'b0;
                    who = next_in_turn(others, prev);
                    if (!cfg_ror || br_in != 0) phase = 0;
                    else if (who >= 0) begin owner = who; prev = who; end
                    else phase = 4;
                end
                4: begin
                    who = next_in_turn(ch_req, prev);
                    if (br_in != 0) phase = 0;
                    else if (who >= 0) begin phase = 3; owner = who; prev = who; end
                end
                default: phase = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock and compare every output with the model.
    task automatic step();
        logic [3:0] e_br;
        logic [NC-1:0] e_gnt;
        @(posedge clk);
        @(negedge clk);
        e_br  = (phase == 1) ? (4'b1 << cfg_lvl) : 4'b0;
        e_gnt = (phase == 3) ? (NC'(1) << owner) : '0;
        chk(br_out == e_br, "R1 model br_out", int'(br_out), int'(e_br));
        chk(bbsy == (phase >= 2), "R5 model bbsy", int'(bbsy), int'(phase >= 2));
        chk(ch_gnt == e_gnt, "R11 model ch_gnt", int'(ch_gnt), int'(e_gnt));
        chk(bg_out == (bg_in && phase != 1), "R10 model bg_out",
            int'(bg_out), int'(bg_in && phase != 1));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        chk(br_out == 0 && bbsy == 0 && ch_gnt == 0, "R1 reset state", int'({br_out, bbsy, ch_gnt}), 0);
        rst = 1'b0;

        // Demand, level 3, despite a foreign request on that level.
        ch_req = 4'b0001; br_in = 4'b1000;
        step();
        chk(br_out == 4'b1000, "R4 demand request", int'(br_out), 8);
        bg_in = 1'b1; br_in = 0;
        step();
        chk(bbsy && br_out == 0 && ch_gnt == 0, "R5 busy before grant", int'({bbsy, br_out}), 16);
        bg_in = 1'b0;
        step();
        chk(ch_gnt == 4'b0001, "R5 channel grant", int'(ch_gnt), 1);
        step(); step();
        chk(bbsy == 1, "R6 held while busy", int'(bbsy), 1);
        ch_done = 4'b0001; ch_req = 0;
        step();
        chk(bbsy == 0 && br_out == 0, "R6 release when done", int'(bbsy), 0);
        ch_done = 0;

        // Fair mode, level 1, channel 2.
        cfg_fair = 1'b1; cfg_lvl = 2'd1; br_in = 4'b0010; ch_req = 4'b0100;
        step();
        chk(br_out == 0, "R3 fair waits", int'(br_out), 0);
        step(); step();
        chk(br_out == 0, "R3 fair still waits", int'(br_out), 0);
        br_in = 0;
        step();
        chk(br_out == 4'b0010, "R2 level 1 for channel 2", int'(br_out), 2);
        bg_in = 1'b1;
        step();
        bg_in = 1'b0;
        step();
        chk(ch_gnt == 4'b0100, "R3 fair grant", int'(ch_gnt), 4);
        ch_berr = 4'b0100; ch_req = 0;
        step();
        chk(bbsy == 0, "R7 bus error ends access", int'(bbsy), 0);
        ch_berr = 0;

        // Grant forwarding.
        cfg_fair = 1'b0; bg_in = 1'b1;
        step();
        chk(bg_out == 1, "R10 forward while idle", int'(bg_out), 1);
        bg_in = 1'b0; ch_req = 4'b0001;
        step();
        bg_in = 1'b1;
        #1;
        chk(bg_out == 0, "R10 grant consumed", int'(bg_out), 0);
        cfg_ror = 1'b1;
        step();
        chk(bg_out == 1 && bbsy == 1, "R10 forward while holding", int'(bg_out), 1);
        bg_in = 1'b0;
        step();
        chk(ch_gnt == 4'b0001, "R11 channel 0 after 3", int'(ch_gnt), 1);

        // Release on request.
        ch_req = 4'b0011; br_in = 4'b0100;
        step(); step();
        chk(bbsy == 1 && ch_gnt == 4'b0001, "R8 no release while busy", int'(ch_gnt), 1);
        br_in = 0; ch_done = 4'b0001; ch_req = 4'b0010;
        step();
        chk(ch_gnt == 4'b0010 && bbsy && br_out == 0, "R9 handoff", int'(ch_gnt), 2);
        ch_done = 4'b0010; ch_req = 0;
        step();
        chk(bbsy == 1 && ch_gnt == 0, "R9 park", int'({bbsy, ch_gnt}), 16);
        ch_done = 0;
        step();
        ch_req = 4'b1000;
        step();
        chk(ch_gnt == 4'b1000 && br_out == 0, "R9 park regrant", int'(ch_gnt), 8);
        ch_req = 4'b0001; ch_done = 4'b1000; br_in = 4'b0001;
        step();
        chk(bbsy == 0 && br_out == 0, "R12 gap after release", int'({bbsy, br_out}), 0);
        ch_done = 0; br_in = 0;
        step();
        chk(br_out == 4'b0010, "R8 re-request after gap", int'(br_out), 2);
        bg_in = 1'b1; ch_req = 4'b1111;
        step();
        bg_in = 1'b0;
        step();
        chk(ch_gnt == 4'b0001, "R11 rr start", int'(ch_gnt), 1);
        for (int i = 1; i <= 4; i++) begin
            ch_done = ch_gnt;
            step();
            ch_done = 0;
            chk(ch_gnt == (NC'(1) << (i % NC)), "R11 rr order", int'(ch_gnt), 1 << (i % NC));
        end
        cfg_ror = 1'b0; ch_req = 0; ch_done = ch_gnt;
        step();
        ch_done = 0;
        chk(bbsy == 0, "R6 final release", int'(bbsy), 0);

        // Random phase compared against the model every clock.
        for (int n = 0; n < 2000; n++) begin
            if (n % 250 == 0) begin
                cfg_lvl = 2'($urandom_range(0, 3));
                cfg_fair = 1'($urandom_range(0, 1));
                cfg_ror = 1'($urandom_range(0, 1));
            end
            ch_req  = 4'($urandom);
            ch_done = ($urandom_range(0, 3) == 0) ? (ch_gnt | 4'($urandom)) : 4'b0;
            ch_berr = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
            br_in   = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0;
            bg_in   = ($urandom_range(0, 3) == 0);
            step();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule